// File: doc/BRIEF.md
# I2C Master SCL Phase Timer

This block times the clock line of an I2C master. A byte/acknowledge engine asks it for a START, for a single data bit, or for a STOP. The block then decides when SCL is pulled low and when it is released, when the engine may change SDA, and when SDA should be captured. Every duration comes from three 32-bit timing words that software programs once. Each word packs two 16-bit counts.

The low phase of SCL lasts the programmed low count plus a fixed offset of 2 reference cycles. The high phase lasts the programmed high count plus 7 cycles. The high count does not start until the block senses SCL high on the bus, so a target that stretches the clock lengthens the high phase. Inside the phases, separate counts place the data-change strobe (measured from the fall of SCL) and the sample strobe (measured from the sensed rise). Two further counts set the START hold time and the bus-free time after a STOP.

Between bits the block parks with SCL held low. It stays there as long as the engine needs and leaves only on a bit or STOP request. A hold request from idle pulls SCL low in the same way. Each START, bit and STOP phase ends with a one-cycle done pulse.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset the block is idle. SCL is released (`scl_low`=0) and every strobe and done output is 0.
- R2: The timing words are laid out as follows. `tmg0[31:16]` is the high count and `tmg0[15:0]` the sample count. `tmg1[31:16]` is the low count and `tmg1[15:0]` the change count. `tmg2[31:16]` is the bus-free count and `tmg2[15:0]` the START hold count.
- R3: In idle, a start request starts a START phase one cycle later. SCL stays released for the START hold count in cycles, with a minimum of 1. `start_done` is 1 in the last of those cycles, and SCL is driven low from the next cycle.
- R4: While parked, a bit request drives SCL low for exactly low count + 2 cycles, starting the cycle after the request.
- R5: `data_chg` is a one-cycle pulse in the low phase, in the cycle whose index (the first low cycle is 0) equals the change count.
- R6: After the low phase SCL is released, and the high phase counts only from the first cycle in which `scl_in` is 1. The phase lasts high count + 7 counted cycles. `bit_done` is 1 in the last of them, and SCL is then driven low (parked).
- R7: `data_smp` is a one-cycle pulse in the high phase, at counted index equal to the sample count. It never fires while the clock is being stretched.
- R8: While parked, a stop request runs a low phase as in R4 and R5, then a high phase of high count + 7 counted cycles. `data_chg` fires in the last cycle of that high phase (the SDA release point). Next, SCL stays released for the bus-free count (minimum 1) with `stop_done` in the last cycle, and the block returns to idle.
- R9: In idle, a hold request drives SCL low from the next cycle. SCL then stays low for as long as neither a bit nor a stop request arrives.
- R10: When requests arrive together, start wins over hold in idle, and bit wins over stop while parked.
- R11: Requests are ignored if they are not listed above for the current state: any request during a START, bit or STOP phase, a bit or stop request in idle, a start or hold request while parked.
- R12: A change or sample count at or beyond its phase length never produces a strobe. A START hold or bus-free count of 0 acts as 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| tmg0 | input | 32 | High count (upper half), sample count (lower half) |
| tmg1 | input | 32 | Low count (upper half), change count (lower half) |
| tmg2 | input | 32 | Bus-free count (upper half), START hold count (lower half) |
| req_start | input | 1 | Request a START phase (accepted in idle) |
| req_bit | input | 1 | Request one clock bit (accepted while parked) |
| req_stop | input | 1 | Request a STOP sequence (accepted while parked) |
| req_hold | input | 1 | Pull SCL low and park (accepted in idle) |
| scl_in | input | 1 | SCL level sensed from the bus |
| scl_low | output | 1 | 1 = drive SCL low, 0 = release |
| data_chg | output | 1 | One-cycle strobe: SDA may change now |
| data_smp | output | 1 | One-cycle strobe: sample SDA now |
| start_done | output | 1 | Last cycle of the START hold |
| bit_done | output | 1 | Last cycle of a bit's high phase |
| stop_done | output | 1 | Last cycle of the bus-free time |

## Verification
The assertions check several properties on every cycle. SCL is released and quiet right after reset. The change strobe is a single pulse. Sampling happens only while SCL is released. The block parks low after a START and after a bit, and it is idle right after a STOP. It stays low while parked with no bit or stop request, and its high-phase count stays frozen while a stretching target holds SCL low. Exact phase lengths, strobe positions for given counts, the field layout of the timing words, request priority, ignored requests and the zero-count and out-of-range cases can only be shown by the bench scenarios. There, a behavioural model and direct measurement of run lengths are compared against the requirements under several register settings and stretch lengths.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;

    localparam int REG_W  = 32;
    localparam int HALF_W = REG_W / 2;
    localparam int CNT_W  = HALF_W + 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_PARK,
        ST_BLO,
        ST_BHI,
        ST_SLO,
        ST_SHI,
        ST_FREE
    } phase_e;

    typedef struct packed {
        logic [HALF_W-1:0] hi_cnt;
        logic [HALF_W-1:0] smp_cnt;
        logic [HALF_W-1:0] lo_cnt;
        logic [HALF_W-1:0] chg_cnt;
        logic [HALF_W-1:0] free_cnt;
        logic [HALF_W-1:0] lead_cnt;
    } timing_t;

    function automatic timing_t unpack_timing(input logic [REG_W-1:0] w0,
                                              input logic [REG_W-1:0] w1,
                                              input logic [REG_W-1:0] w2);
        timing_t t;
        t.hi_cnt   = w0[REG_W-1:HALF_W];
        t.smp_cnt  = w0[HALF_W-1:0];
        t.lo_cnt   = w1[REG_W-1:HALF_W];
        t.chg_cnt  = w1[HALF_W-1:0];
        t.free_cnt = w2[REG_W-1:HALF_W];
        t.lead_cnt = w2[HALF_W-1:0];
        return t;
    endfunction

    function automatic logic is_low_phase(input phase_e p);
        return (p == ST_BLO) || (p == ST_SLO);
    endfunction

    function automatic logic is_high_phase(input phase_e p);
        return (p == ST_BHI) || (p == ST_SHI);
    endfunction

    function automatic logic is_timed(input phase_e p);
        return (p != ST_IDLE) && (p != ST_PARK);
    endfunction

endpackage

// File: rtl/sclgen_fields.sv
module sclgen_fields
    import sclgen_pkg::*;
#(
    parameter int LOW_EXTRA  = 2,
    parameter int HIGH_EXTRA = 7
) (
    input  logic [REG_W-1:0] w0,
    input  logic [REG_W-1:0] w1,
    input  logic [REG_W-1:0] w2,
    input  phase_e           phase,
    output timing_t          tm,
    output logic [CNT_W-1:0] phase_len
);

    always_comb begin
        tm = unpack_timing(w0, w1, w2);
        unique case (phase)
            ST_LEAD:        phase_len = {1'b0, tm.lead_cnt};
            ST_BLO, ST_SLO: phase_len = {1'b0, tm.lo_cnt} + CNT_W'(LOW_EXTRA);
            ST_BHI, ST_SHI: phase_len = {1'b0, tm.hi_cnt} + CNT_W'(HIGH_EXTRA);
            ST_FREE:        phase_len = {1'b0, tm.free_cnt};
            default:        phase_len = '0;
        endcase
    end

endmodule

// File: rtl/sclgen_phase_ctr.sv
module sclgen_phase_ctr
    import sclgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             adv,
    input  logic [CNT_W-1:0] len,
    output logic [CNT_W-1:0] cnt,
    output logic             at_end
);

    localparam int EW = CNT_W + 1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)          cnt_q <= '0;
        else if (restart) cnt_q <= '0;
        else if (adv)     cnt_q <= cnt_q + CNT_W'(1);
    end

    // A length of zero ends on the first advancing cycle, as a length of one.
    assign at_end = adv && (({1'b0, cnt_q} + EW'(1)) >= {1'b0, len});
    assign cnt    = cnt_q;

endmodule

// File: rtl/sclgen_seq.sv
module sclgen_seq
    import sclgen_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   req_start,
    input  logic   req_bit,
    input  logic   req_stop,
    input  logic   req_hold,
    input  logic   at_end,
    output phase_e phase,
    output logic   restart
);

    phase_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (req_start)     st_d = ST_LEAD;
                else if (req_hold) st_d = ST_PARK;
            end
            ST_LEAD: if (at_end) st_d = ST_PARK;
            ST_PARK: begin
                if (req_bit)       st_d = ST_BLO;
                else if (req_stop) st_d = ST_SLO;
            end
            ST_BLO:  if (at_end) st_d = ST_BHI;
            ST_BHI:  if (at_end) st_d = ST_PARK;
            ST_SLO:  if (at_end) st_d = ST_SHI;
            ST_SHI:  if (at_end) st_d = ST_FREE;
            ST_FREE: if (at_end) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    assign phase   = st_q;
    assign restart = (st_d != st_q);

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import sclgen_pkg::*;
#(
    parameter int LOW_EXTRA  = 2,
    parameter int HIGH_EXTRA = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] tmg0,
    input  logic [REG_W-1:0] tmg1,
    input  logic [REG_W-1:0] tmg2,
    input  logic             req_start,
    input  logic             req_bit,
    input  logic             req_stop,
    input  logic             req_hold,
    input  logic             scl_in,
    output logic             scl_low,
    output logic             data_chg,
    output logic             data_smp,
    output logic             start_done,
    output logic             bit_done,
    output logic             stop_done
);

    phase_e           st_q;
    timing_t          tm;
    logic [CNT_W-1:0] len;
    logic [CNT_W-1:0] cnt_q;
    logic             restart;
    logic             adv;
    logic             at_end;

    sclgen_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_start (req_start),
        .req_bit   (req_bit),
        .req_stop  (req_stop),
        .req_hold  (req_hold),
        .at_end    (at_end),
        .phase     (st_q),
        .restart   (restart)
    );

    sclgen_fields #(
        .LOW_EXTRA  (LOW_EXTRA),
        .HIGH_EXTRA (HIGH_EXTRA)
    ) u_fields (
        .w0        (tmg0),
        .w1        (tmg1),
        .w2        (tmg2),
        .phase     (st_q),
        .tm        (tm),
        .phase_len (len)
    );

    // High phases count only after SCL has been seen high once.
    assign adv = is_timed(st_q) &&
                 (!is_high_phase(st_q) || (cnt_q != '0) || scl_in);

    sclgen_phase_ctr u_ctr (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .adv     (adv),
        .len     (len),
        .cnt     (cnt_q),
        .at_end  (at_end)
    );

    assign scl_low    = (st_q == ST_PARK) || is_low_phase(st_q);
    assign data_chg   = (adv && is_low_phase(st_q) && (cnt_q == {1'b0, tm.chg_cnt})) ||
                        ((st_q == ST_SHI) && at_end);
    assign data_smp   = adv && (st_q == ST_BHI) && (cnt_q == {1'b0, tm.smp_cnt});
    assign start_done = at_end && (st_q == ST_LEAD);
    assign bit_done   = at_end && (st_q == ST_BHI);
    assign stop_done  = at_end && (st_q == ST_FREE);

endmodule

// File: rtl/sclgen_chk.sv
module sclgen_chk
    import sclgen_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             req_bit,
    input logic             req_stop,
    input logic             scl_in,
    input logic             scl_low,
    input logic             data_chg,
    input logic             data_smp,
    input logic             start_done,
    input logic             bit_done,
    input logic             stop_done,
    input phase_e           phase,
    input logic [CNT_W-1:0] cnt
);

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!scl_low && !data_chg && !data_smp));

    a_r5_chg_single: assert property (@(posedge clk) disable iff (rst)
        data_chg |=> !data_chg);

    a_r7_smp_released: assert property (@(posedge clk) disable iff (rst)
        data_smp |-> !scl_low);

    a_r7_smp_single: assert property (@(posedge clk) disable iff (rst)
        data_smp |=> !data_smp);

    a_r3_park_after_start: assert property (@(posedge clk) disable iff (rst)
        start_done |=> scl_low);

    a_r6_park_after_bit: assert property (@(posedge clk) disable iff (rst)
        bit_done |=> scl_low);

    a_r8_idle_after_stop: assert property (@(posedge clk) disable iff (rst)
        stop_done |=> (!scl_low && phase == ST_IDLE));

    a_r9_hold_low: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_PARK && !req_bit && !req_stop) |=> scl_low);

    a_r6_stretch_freeze: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_BHI && cnt == '0 && !scl_in) |=> (phase == ST_BHI && cnt == '0));

endmodule

bind scl_timing_gen sclgen_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_bit    (req_bit),
    .req_stop   (req_stop),
    .scl_in     (scl_in),
    .scl_low    (scl_low),
    .data_chg   (data_chg),
    .data_smp   (data_smp),
    .start_done (start_done),
    .bit_done   (bit_done),
    .stop_done  (stop_done),
    .phase      (st_q),
    .cnt        (cnt_q)
);

// File: tb/tb_scl_timing_gen.sv
`timescale 1ns/1ps
module tb_scl_timing_gen;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst = 1'b1;
    logic [31:0] tmg0 = '0, tmg1 = '0, tmg2 = '0;
    logic        req_start = 0, req_bit = 0, req_stop = 0, req_hold = 0, stretch = 0;
    wire         scl_in;
    logic        scl_low, data_chg, data_smp, start_done, bit_done, stop_done;

    assign scl_in = !scl_low && !stretch;

    scl_timing_gen dut (
        .clk(clk), .rst(rst), .tmg0(tmg0), .tmg1(tmg1), .tmg2(tmg2),
        .req_start(req_start), .req_bit(req_bit), .req_stop(req_stop), .req_hold(req_hold),
        .scl_in(scl_in), .scl_low(scl_low), .data_chg(data_chg), .data_smp(data_smp),
        .start_done(start_done), .bit_done(bit_done), .stop_done(stop_done)
    );

    int total = 0, bad = 0, cyc = 0;
    bit model_on = 0, finished = 0;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Field values per R2
    function automatic int f_hi();   return int'(tmg0[31:16]); endfunction
    function automatic int f_smp();  return int'(tmg0[15:0]);  endfunction
    function automatic int f_lo();   return int'(tmg1[31:16]); endfunction
    function automatic int f_chg();  return int'(tmg1[15:0]);  endfunction
    function automatic int f_free(); return int'(tmg2[31:16]); endfunction
    function automatic int f_lead(); return int'(tmg2[15:0]);  endfunction
    function automatic int atleast1(input int v); return (v < 1) ? 1 : v; endfunction

    // Behavioural reference: 0 idle,1 lead,2 park,3 bit low,4 bit high,5 stop low,6 stop high,7 free
    int m_st = 0, m_rem = 0, m_len0 = 0;
    bit m_seen = 0;

    task automatic m_enter(input int s);
        m_st = s;
        m_seen = 0;
        case (s)
            1: m_len0 = atleast1(f_lead());
            3, 5: m_len0 = f_lo() + 2;
            4, 6: m_len0 = f_hi() + 7;
            7: m_len0 = atleast1(f_free());
            default: m_len0 = 0;
        endcase
        m_rem = m_len0;
    endtask

    always @(negedge clk) begin
        #1;
        if (rst) begin
            m_st = 0; m_rem = 0; m_len0 = 0; m_seen = 0;
        end else if (model_on && !finished) begin
            bit lowp, highp, act, adv, fin;
            int idx;
            lowp  = (m_st == 3) || (m_st == 5);
            highp = (m_st == 4) || (m_st == 6);
            act   = (m_st != 0) && (m_st != 2);
            adv   = act && (!highp || m_seen || scl_in);
            idx   = m_len0 - m_rem;
            fin   = adv && (m_rem == 1);
            chk("R4/R9 model scl_low", int'(scl_low), int'((m_st == 2) || lowp));
            chk("R5/R8 model data_chg", int'(data_chg),
                int'((lowp && adv && idx == f_chg()) || (m_st == 6 && fin)));
            chk("R7 model data_smp", int'(data_smp), int'(m_st == 4 && adv && idx == f_smp()));
            chk("R3 model start_done", int'(start_done), int'(m_st == 1 && fin));
            chk("R6 model bit_done", int'(bit_done), int'(m_st == 4 && fin));
            chk("R8 model stop_done", int'(stop_done), int'(m_st == 7 && fin));
            if (fin) begin
                case (m_st)
                    1: m_enter(2);
                    3: m_enter(4);
                    4: m_enter(2);
                    5: m_enter(6);
                    6: m_enter(7);
                    default: m_enter(0);
                endcase
            end else if (adv) begin
                m_rem--;
                if (highp) m_seen = 1;
            end else if (m_st == 0) begin
                if (req_start) m_enter(1);
                else if (req_hold) m_enter(2);
            end else if (m_st == 2) begin
                if (req_bit) m_enter(3);
                else if (req_stop) m_enter(5);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    task automatic issue(input bit s, input bit b, input bit p, input bit h, input bit st);
        @(negedge clk);
        req_start = s; req_bit = b; req_stop = p; req_hold = h; stretch = st;
        @(negedge clk);
        req_start = 0; req_bit = 0; req_stop = 0; req_hold = 0;
        #1;
    endtask

    task automatic do_start(input bit with_hold);
        int n = 0, done_at = -1;
        issue(1, 0, 0, with_hold, 0);
        while (!scl_low && n < 70000) begin
            if (start_done) done_at = n;
            n++;
            @(negedge clk); #1;
        end
        chk("R3/R10 start hold length", n, atleast1(f_lead()));
        chk("R3 start_done position", done_at, atleast1(f_lead()) - 1);
    endtask

    task automatic low_phase(input bit poke, output int n, output int chg_at);
        n = 0; chg_at = -1;
        while (scl_low && n < 70000) begin
            if (data_chg) chg_at = n;
            n++;
            @(negedge clk);
            if (poke) begin
                req_start = (n < f_lo()); req_bit = (n < f_lo());
                req_stop = (n < f_lo());  req_hold = (n < f_lo());
            end
            #1;
        end
    endtask

    task automatic do_bit(input int s, input bit poke, input bit with_stop);
        int n, chg_at, m = 0, smp_at = -1, done_at = -1;
        int exp_chg, exp_smp;
        issue(0, 1, with_stop, 0, s > 0);
        low_phase(poke, n, chg_at);
        exp_chg = (f_chg() < f_lo() + 2) ? f_chg() : -1;
        chk("R2/R4/R11 bit low length", n, f_lo() + 2);
        chk("R5/R12 change strobe index", chg_at, exp_chg);
        while (!scl_low && m < 70000) begin
            if (data_smp) smp_at = m;
            if (bit_done) done_at = m;
            m++;
            @(negedge clk);
            stretch = (m < s);
            #1;
        end
        exp_smp = (f_smp() < f_hi() + 7) ? s + f_smp() : -1;
        chk("R6/R10 high length with stretch", m, s + f_hi() + 7);
        chk("R7/R12 sample strobe index", smp_at, exp_smp);
        chk("R6 bit_done position", done_at, m - 1);
    endtask

    task automatic do_stop();
        int n, chg_at, m = 0, c2 = -1, done_at = -1;
        issue(0, 0, 1, 0, 0);
        low_phase(0, n, chg_at);
        chk("R8 stop low length", n, f_lo() + 2);
        chk("R8 stop low change index", chg_at, (f_chg() < f_lo() + 2) ? f_chg() : -1);
        while (done_at < 0 && m < 140000) begin
            if (data_chg) c2 = m;
            if (stop_done) done_at = m;
            if (scl_low) done_at = -2;
            m++;
            @(negedge clk); #1;
        end
        chk("R8 SDA release strobe", c2, f_hi() + 6);
        chk("R8/R12 stop_done position", done_at, f_hi() + 7 + atleast1(f_free()) - 1);
        chk("R8 idle after stop", int'(scl_low), 0);
    endtask

    task automatic watch(input string tag, input int cycles, input bit exp_low);
        int errs = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk); #1;
            if (scl_low != exp_low || data_chg || data_smp || start_done || bit_done || stop_done)
                errs++;
        end
        chk(tag, errs, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 0; model_on = 1;
        #1;
        chk("R1 reset scl_low", int'(scl_low), 0);
        chk("R1 reset strobes", int'(data_chg | data_smp), 0);
        chk("R1 reset done pulses", int'(start_done | bit_done | stop_done), 0);

        // 100 kHz style setting
        tmg0 = {16'd103, 16'd41}; tmg1 = {16'd128, 16'd48}; tmg2 = {16'd113, 16'd113};
        do_start(0);
        do_bit(0, 0, 0);
        do_bit(5, 0, 0);
        do_bit(0, 1, 0);            // R11 requests during bit ignored
        do_bit(0, 0, 1);            // R10 bit wins over stop
        do_stop();

        issue(0, 1, 1, 0, 0);       // R11 bit/stop ignored in idle
        watch("R11 idle ignores bit/stop", 20, 0);
        issue(0, 0, 0, 1, 0);       // R9 hold
        watch("R9 hold keeps SCL low", 60, 1);
        do_bit(2, 0, 0);
        do_stop();

        // small counts
        tmg0 = {16'd3, 16'd2}; tmg1 = {16'd4, 16'd1}; tmg2 = {16'd5, 16'd2};
        do_start(1);                // R10 start wins over hold
        do_bit(0, 0, 0);
        issue(1, 0, 0, 1, 0);       // R11 start/hold ignored while parked
        watch("R11 park ignores start/hold", 20, 1);
        do_bit(3, 1, 0);
        do_stop();

        // R12 zero and out-of-range counts
        tmg0 = {16'd2, 16'd20}; tmg1 = {16'd1, 16'd9}; tmg2 = 32'd0;
        do_start(0);
        do_bit(0, 0, 0);
        do_stop();

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule